// File: doc/BRIEF.md
# Wavefront Array Matrix Multiplier

This block multiplies two square matrices on a small grid of multiply-accumulate elements that are scheduled by data arrival instead of a global beat. Operands of the left matrix enter along the west edge, one lane per row. Operands of the right matrix enter along the north edge, one lane per column. Each lane ends in a small edge buffer that memory can fill before the run starts. Inside the grid, neighbouring elements are joined by one-entry links. An element fires when both of its input operands are present and its outgoing links are empty. When it fires it adds the product to its accumulator, passes the row operand east and passes the column operand south. Elements on the east and south borders drop the operand they would have passed on.

After a `start` pulse the top-left element fires first. Computation then spreads outward as diagonal fronts. The origin can launch the next front while the previous one is still moving, so successive fronts overlap. `done` rises once every element has fired once per inner-product term. The full product can then be read one element at a time through a combinational read port. Both the result and `done` stay unchanged until the next accepted `start`.

Top module: `wfmm_array`

## Requirements
- R1: After reset, `done` is 0, every result reads as 0 and every edge lane's ready is 1.
- R2: Each edge buffer holds GRID (default 2) operands, and its ready is low while it is full. An operand enters on a clock edge where valid and ready are both high. West lane r uses bits r*DATA_W upward and feeds row r. North lane c feeds column c.
- R3: No element computes before an accepted `start`. Preloaded operands leave every result and `done` unchanged.
- R4: A `start` taken while idle clears every accumulator to zero and drops `done` on the following cycle.
- R5: An element fires only when both of its inputs hold an operand and its outgoing one-entry links are empty. The top-left element fires first. If only the first west-0 and north-0 operands are present, only result (0,0) changes, and it becomes their product.
- R6: East and south border elements discard the operands they would forward. After a run every edge buffer is drained, and the results do not move while the block waits.
- R7: `done` rises after every element has fired GRID times. Result (i,j) then equals the sum over k of A[i][k]*B[k][j]. West lane i supplies A[i][0] then A[i][1]. North lane j supplies B[0][j] then B[1][j].
- R8: The results do not depend on feed timing. This includes random stalls on any lane and operands that arrive after `start`.
- R9: `done` and the results hold until the next accepted `start`. A `start` that arrives during a run is ignored.
- R10: `rd_row` and `rd_col` select which result appears on `rd_data`, combinationally.
- R11: The accumulator is 2*DATA_W+log2(GRID) bits wide. With every operand at its maximum, the result is exact (2*255*255 = 130050 for 8-bit data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| west_valid | input | GRID | Operand present on each row lane |
| west_data | input | GRID*DATA_W | Row-lane operands, lane r at bits r*DATA_W |
| west_ready | output | GRID | Row-lane edge buffer has room |
| north_valid | input | GRID | Operand present on each column lane |
| north_data | input | GRID*DATA_W | Column-lane operands, lane c at bits c*DATA_W |
| north_ready | output | GRID | Column-lane edge buffer has room |
| rd_row | input | log2(GRID) | Result row select |
| rd_col | input | log2(GRID) | Result column select |
| rd_data | output | 2*DATA_W+log2(GRID) | Selected accumulator |
| done | output | 1 | All elements finished |

## Verification
The case that is hardest to reach from the ports is a mid-run state where some elements hold an operand and wait for their partner, or for a downstream link to empty. Normal preloaded runs rush through that state in a few cycles. The stimulus reaches it on purpose in three ways. It feeds only the first pair of origin operands and then inspects the partial results while the block is stalled. It feeds lanes after `start` with independent random gaps, so fronts meet late operands in varied orders. It also repeats `start` mid-run to confirm that the busy state ignores it.

// File: rtl/wfmm_pkg.sv
`timescale 1ns/1ps
package wfmm_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // index width that stays legal for a count of one
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wfmm_edge_buf.sv
`timescale 1ns/1ps
module wfmm_edge_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic              full,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  localparam int PTR_W = wfmm_pkg::idx_width(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign valid   = (count != '0);
  assign dout    = mem[rd_ptr];
  assign do_push = push & ~full;
  assign do_pop  = pop & valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wfmm_link.sv
`timescale 1ns/1ps
module wfmm_link #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wfmm_pe.sv
`timescale 1ns/1ps
module wfmm_pe #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 17,
  parameter int GRID   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              enable,
  input  logic              w_valid,
  input  logic [DATA_W-1:0] w_data,
  input  logic              n_valid,
  input  logic [DATA_W-1:0] n_data,
  input  logic              east_busy,
  input  logic              south_busy,
  output logic              fire,
  output logic              fed,
  output logic              blocked,
  output logic              full,
  output logic [ACC_W-1:0]  acc
);
  localparam int CNT_W = $clog2(GRID + 1);

  logic [CNT_W-1:0] fired_cnt;

  function automatic logic [ACC_W-1:0] mac_step(input logic [ACC_W-1:0] sum,
                                                input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y);
    return sum + (ACC_W'(x) * ACC_W'(y));
  endfunction

  assign fed     = w_valid & n_valid;
  assign blocked = east_busy | south_busy;
  assign full    = (fired_cnt == CNT_W'(GRID));
  assign fire    = enable & fed & ~blocked & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      fired_cnt <= '0;
    end else if (clear) begin
      acc       <= '0;
      fired_cnt <= '0;
    end else if (fire) begin
      acc       <= mac_step(acc, w_data, n_data);
      fired_cnt <= fired_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wfmm_array.sv
`timescale 1ns/1ps
module wfmm_array #(
  parameter int DATA_W = 8,
  parameter int GRID   = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start,
  input  logic [GRID-1:0]                             west_valid,
  input  logic [GRID*DATA_W-1:0]                      west_data,
  output logic [GRID-1:0]                             west_ready,
  input  logic [GRID-1:0]                             north_valid,
  input  logic [GRID*DATA_W-1:0]                      north_data,
  output logic [GRID-1:0]                             north_ready,
  input  logic [wfmm_pkg::idx_width(GRID)-1:0]        rd_row,
  input  logic [wfmm_pkg::idx_width(GRID)-1:0]        rd_col,
  output logic [2*DATA_W+$clog2(GRID)-1:0]            rd_data,
  output logic                                        done
);
  import wfmm_pkg::*;

  localparam int IDX_W  = idx_width(GRID);
  localparam int ACC_W  = 2*DATA_W + $clog2(GRID);
  localparam int PE_CNT = GRID * GRID;

  run_state_e state;
  logic       run_en, start_ok, all_full;

  logic [PE_CNT-1:0] fire_flat, fed_flat, blocked_flat, full_flat;
  logic [ACC_W-1:0]  acc_arr [PE_CNT];

  // operand presented to the west / north side of element (r,c)
  logic              h_valid [GRID][GRID];
  logic [DATA_W-1:0] h_data  [GRID][GRID];
  logic              v_valid [GRID][GRID];
  logic [DATA_W-1:0] v_data  [GRID][GRID];
  logic [GRID-1:0]   west_full, north_full;

  assign run_en   = (state == ST_RUN);
  assign start_ok = start & (state == ST_IDLE);
  assign all_full = &full_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else if (start_ok) begin
      state <= ST_RUN;
      done  <= 1'b0;
    end else if (run_en && all_full) begin
      state <= ST_IDLE;
      done  <= 1'b1;
    end
  end

  genvar r, c;
  generate
    for (r = 0; r < GRID; r++) begin : g_west
      wfmm_edge_buf #(.DATA_W(DATA_W), .DEPTH(GRID)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push(west_valid[r]), .din(west_data[r*DATA_W +: DATA_W]),
        .pop(fire_flat[r*GRID]),
        .full(west_full[r]), .valid(h_valid[r][0]), .dout(h_data[r][0])
      );
      assign west_ready[r] = ~west_full[r];
    end

    for (c = 0; c < GRID; c++) begin : g_north
      wfmm_edge_buf #(.DATA_W(DATA_W), .DEPTH(GRID)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push(north_valid[c]), .din(north_data[c*DATA_W +: DATA_W]),
        .pop(fire_flat[c]),
        .full(north_full[c]), .valid(v_valid[0][c]), .dout(v_data[0][c])
      );
      assign north_ready[c] = ~north_full[c];
    end

    for (r = 0; r < GRID; r++) begin : g_row
      for (c = 0; c < GRID; c++) begin : g_col
        logic e_busy, s_busy;

        if (c > 0) begin : g_hlink
          wfmm_link #(.DATA_W(DATA_W)) u_link (
            .clk(clk), .rst_n(rst_n),
            .push(fire_flat[r*GRID + c - 1]), .din(h_data[r][c-1]),
            .pop(fire_flat[r*GRID + c]),
            .valid(h_valid[r][c]), .dout(h_data[r][c])
          );
        end

        if (r > 0) begin : g_vlink
          wfmm_link #(.DATA_W(DATA_W)) u_link (
            .clk(clk), .rst_n(rst_n),
            .push(fire_flat[(r-1)*GRID + c]), .din(v_data[r-1][c]),
            .pop(fire_flat[r*GRID + c]),
            .valid(v_valid[r][c]), .dout(v_data[r][c])
          );
        end

        if (c < GRID - 1) begin : g_east
          assign e_busy = h_valid[r][c+1];
        end else begin : g_east_edge
          assign e_busy = 1'b0;
        end

        if (r < GRID - 1) begin : g_south
          assign s_busy = v_valid[r+1][c];
        end else begin : g_south_edge
          assign s_busy = 1'b0;
        end

        wfmm_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W), .GRID(GRID)) u_pe (
          .clk(clk), .rst_n(rst_n),
          .clear(start_ok), .enable(run_en),
          .w_valid(h_valid[r][c]), .w_data(h_data[r][c]),
          .n_valid(v_valid[r][c]), .n_data(v_data[r][c]),
          .east_busy(e_busy), .south_busy(s_busy),
          .fire(fire_flat[r*GRID + c]), .fed(fed_flat[r*GRID + c]),
          .blocked(blocked_flat[r*GRID + c]), .full(full_flat[r*GRID + c]),
          .acc(acc_arr[r*GRID + c])
        );
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int ri = 0; ri < GRID; ri++) begin
      for (int ci = 0; ci < GRID; ci++) begin
        if (rd_row == IDX_W'(ri) && rd_col == IDX_W'(ci))
          rd_data = acc_arr[ri*GRID + ci];
      end
    end
  end
endmodule

// File: rtl/wfmm_checker.sv
`timescale 1ns/1ps
module wfmm_checker #(
  parameter int PE_CNT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              running,
  input logic [PE_CNT-1:0] fire,
  input logic [PE_CNT-1:0] fed,
  input logic [PE_CNT-1:0] blocked,
  input logic [PE_CNT-1:0] full
);
  logic origin_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 origin_seen <= 1'b0;
    else if (start && !running) origin_seen <= 1'b0;
    else if (fire[0])           origin_seen <= 1'b1;
  end

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (fire == '0));

  a_r4_start_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> !done);

  a_r7_done_after_all: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (&full));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  genvar i;
  generate
    for (i = 0; i < PE_CNT; i++) begin : g_pe
      a_r5_fire_fed: assert property (@(posedge clk) disable iff (!rst_n)
        fire[i] |-> fed[i]);
      a_r5_fire_room: assert property (@(posedge clk) disable iff (!rst_n)
        fire[i] |-> !blocked[i]);
      a_r7_no_excess: assert property (@(posedge clk) disable iff (!rst_n)
        full[i] |-> !fire[i]);
      if (i > 0) begin : g_follow
        a_r5_origin_first: assert property (@(posedge clk) disable iff (!rst_n)
          fire[i] |-> origin_seen);
      end
    end
  endgenerate
endmodule

bind wfmm_array wfmm_checker #(.PE_CNT(GRID*GRID)) u_wfmm_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .running(run_en),
  .fire(fire_flat), .fed(fed_flat), .blocked(blocked_flat), .full(full_flat)
);

// File: tb/test_wfmm_array.sv
`timescale 1ns/1ps
module test_wfmm_array;
  typedef logic [7:0] mat_t [2][2];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  west_valid = '0, north_valid = '0;
  logic [15:0] west_data = '0, north_data = '0;
  logic [1:0]  west_ready, north_ready;
  logic        rd_row = 1'b0, rd_col = 1'b0;
  logic [16:0] rd_data;
  logic        done;

  int checks = 0;
  int errors = 0;
  int runs_checked = 0;
  logic [16:0] exp_q [$];
  logic [16:0] last_exp [2][2];

  always #5 clk = ~clk;

  wfmm_array #(.DATA_W(8), .GRID(2)) i_wfmm_array (
    .clk(clk), .rst_n(rst_n), .start(start),
    .west_valid(west_valid), .west_data(west_data), .west_ready(west_ready),
    .north_valid(north_valid), .north_data(north_data), .north_ready(north_ready),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [16:0] ref_c(input mat_t a, input mat_t b, input int i, input int j);
    logic [16:0] s = '0;
    for (int k = 0; k < 2; k++) s = s + 17'(a[i][k]) * 17'(b[k][j]);
    return s;
  endfunction

  task automatic read_c(input int r, input int c, output logic [16:0] v);
    rd_row = 1'(r);
    rd_col = 1'(c);
    #1;
    v = rd_data;
  endtask

  task automatic push_one(input bit north, input int idx, input logic [7:0] v, input int gap);
    repeat ($urandom_range(gap, 0)) @(negedge clk);
    forever begin
      @(negedge clk);
      if (north ? north_ready[idx] : west_ready[idx]) break;
    end
    if (north) begin
      north_valid[idx] = 1'b1;
      north_data[idx*8 +: 8] = v;
    end else begin
      west_valid[idx] = 1'b1;
      west_data[idx*8 +: 8] = v;
    end
    @(negedge clk);
    if (north) north_valid[idx] = 1'b0;
    else       west_valid[idx]  = 1'b0;
  endtask

  task automatic feed_lane(input bit north, input int idx, input logic [7:0] v0,
                           input logic [7:0] v1, input bit skip0, input int gap);
    if (!skip0) push_one(north, idx, v0, gap);
    push_one(north, idx, v1, gap);
  endtask

  // west lane i: A[i][0], A[i][1]; north lane j: B[0][j], B[1][j]
  task automatic feed_all(input mat_t a, input mat_t b, input int gap, input bit skip_origin);
    fork
      feed_lane(1'b0, 0, a[0][0], a[0][1], skip_origin, gap);
      feed_lane(1'b0, 1, a[1][0], a[1][1], 1'b0, gap);
      feed_lane(1'b1, 0, b[0][0], b[1][0], skip_origin, gap);
      feed_lane(1'b1, 1, b[0][1], b[1][1], 1'b0, gap);
    join
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push_expected(input mat_t a, input mat_t b);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) begin
        exp_q.push_back(ref_c(a, b, i, j));
        last_exp[i][j] = ref_c(a, b, i, j);
      end
  endtask

  task automatic wait_checked(input int target);
    for (int t = 0; t < 3000; t++) begin
      if (runs_checked >= target) break;
      @(negedge clk);
    end
    check(runs_checked >= target, "R7 done never rose", runs_checked, target);
  endtask

  task automatic after_run_checks();
    logic [16:0] v;
    check(west_ready == 2'b11 && north_ready == 2'b11, "R6 edge buffers drained",
          {west_ready, north_ready}, 4'hF);
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R9 done holds", done, 1);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) begin
        read_c(i, j, v);
        check(v == last_exp[i][j], "R6 result stable after run", v, last_exp[i][j]);
      end
  endtask

  // mode 0: preload then start; mode 1: start then feed; mode 2: feed with a start repeated mid-run
  task automatic run_case(input mat_t a, input mat_t b, input int gap, input int mode);
    logic [16:0] v;
    logic [16:0] prev [2][2];
    int target;
    prev = last_exp;
    target = runs_checked + 1;
    if (mode == 0) begin
      feed_all(a, b, gap, 1'b0);
      check(west_ready == 2'b00 && north_ready == 2'b00, "R2 ready low when full",
            {west_ready, north_ready}, 0);
      repeat (20) @(negedge clk);
      check(done == 1'b1, "R3 preload leaves done", done, 1);
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++) begin
          read_c(i, j, v);
          check(v == prev[i][j], "R3 preload leaves results", v, prev[i][j]);
        end
      push_expected(a, b);
      pulse_start();
      check(done == 1'b0, "R4 done drops after start", done, 0);
      read_c(1, 1, v);
      check(v == 17'd0, "R4 accumulator cleared", v, 0);
    end else if (mode == 1) begin
      push_expected(a, b);
      pulse_start();
      feed_all(a, b, gap, 1'b0);
    end else begin
      push_expected(a, b);
      pulse_start();
      fork
        feed_all(a, b, gap, 1'b0);
        begin
          repeat (4) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      join
    end
    wait_checked(target);
    after_run_checks();
  endtask

  // scoreboard monitor: pops expected results once done rises
  initial begin
    logic [16:0] v, e;
    forever begin
      @(posedge done);
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++) begin
          read_c(i, j, v);
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected result set", v, 0);
          end else begin
            e = exp_q.pop_front();
            check(v == e, "R7 R8 R10 product element", v, e);
          end
        end
      runs_checked++;
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", runs_checked, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mat_t a, b;
    logic [16:0] v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(west_ready == 2'b11 && north_ready == 2'b11, "R1 ready after reset",
          {west_ready, north_ready}, 4'hF);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) begin
        read_c(i, j, v);
        check(v == 17'd0, "R1 result after reset", v, 0);
      end

    // R5: only the origin operands present
    a = '{'{8'd3, 8'd4}, '{8'd5, 8'd6}};
    b = '{'{8'd7, 8'd8}, '{8'd9, 8'd10}};
    push_one(1'b0, 0, a[0][0], 0);
    push_one(1'b1, 0, b[0][0], 0);
    pulse_start();
    repeat (8) @(negedge clk);
    read_c(0, 0, v);
    check(v == 17'd21, "R5 origin fired alone", v, 21);
    read_c(0, 1, v);
    check(v == 17'd0, "R5 east neighbour waits", v, 0);
    read_c(1, 0, v);
    check(v == 17'd0, "R5 south neighbour waits", v, 0);
    read_c(1, 1, v);
    check(v == 17'd0, "R5 far element waits", v, 0);
    check(done == 1'b0, "R5 done low mid-run", done, 0);
    push_expected(a, b);
    feed_all(a, b, 2, 1'b1);
    wait_checked(1);
    after_run_checks();

    // fixed preloaded run
    a = '{'{8'd1, 8'd2}, '{8'd3, 8'd4}};
    b = '{'{8'd5, 8'd6}, '{8'd7, 8'd8}};
    run_case(a, b, 0, 0);

    // R11: all operands at maximum
    a = '{'{8'd255, 8'd255}, '{8'd255, 8'd255}};
    b = a;
    run_case(a, b, 1, 0);
    read_c(1, 1, v);
    check(v == 17'd130050, "R11 full-width sum", v, 130050);

    // R8: random values, feeds after start with random stalls
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++) begin
          a[i][j] = 8'($urandom);
          b[i][j] = 8'($urandom);
        end
      run_case(a, b, 3 + n, (n == 3) ? 0 : 1);
    end

    // R9: start repeated while busy must be ignored
    a = '{'{8'd9, 8'd2}, '{8'd7, 8'd11}};
    b = '{'{8'd4, 8'd13}, '{8'd6, 8'd1}};
    run_case(a, b, 6, 2);

    check(exp_q.size() == 0, "R7 all result sets consumed", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule